// File: doc/BRIEF.md
# Dynamic Power Mode Controller

This block decides which clocks run in a processor subsystem. It keeps one of four operating modes: full performance with the PLL in use, active with the PLL bypassed, sleep and deep sleep. From that mode it drives a core-clock enable, a system-clock enable, a PLL enable, a PLL bypass select and a permit for DMA into local memory. The actual clock gating is done elsewhere. This block only produces the enables.

Software writes a control word that carries a bypass bit, a clock multiplier value and a mode request. A changed multiplier does not take effect straight away. A lock counter reloads, and the effective multiplier only moves when the counter finishes. The counter is paused while the PLL is disabled.

Leaving a low-power mode depends on which mode the block is in. In sleep, the generic interrupt or the RTC wakeup brings the block back to full performance or to active, as the stored bypass bit decides. In deep sleep, only the RTC wakeup or reset brings it back, and always to full performance. The RTC wakeup comes from an always-on domain, so it passes through a two-flop synchronizer first.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset:
  - `modeState` is 2'b00 (full performance; 01 = active, 10 = sleep, 11 = deep sleep).
  - `coreClkEn`, `sysClkEn`, `pllEn` and `dmaPermit` are 1, and `pllBypass` is 0.
  - `lockDone` is 1 and `multEff` equals the `MULT_RST` parameter.
- R2: In full or active mode, a write (`cfgWrEn`=1) with no mode request moves the mode to active if `cfgBypass`=1 and to full if `cfgBypass`=0, on the next clock edge.
  - Active drives core, system, PLL and DMA enables to 1 and `pllBypass` to 1.
- R3: A write whose `cfgMult` differs from the pending multiplier clears `lockDone` at the next edge.
  - `lockDone` stays low for exactly `LOCK_RELOAD` clock cycles while the PLL runs.
  - `multEff` keeps its old value until the edge where `lockDone` returns to 1, and takes the new value on that edge.
- R4: A write of the value that is already pending does not restart the lock count. A write of a different value while counting restarts the full count.
- R5: A `cfgModeReq` of 2'b01 written in full or active mode enters sleep.
  - In sleep, `coreClkEn`=0, `dmaPermit`=0, `sysClkEn`=1 and `pllEn`=1.
- R6: In sleep, `irq`=1 at a clock edge wakes the block at that edge. It goes to active if the stored bypass bit is 1 and to full otherwise.
- R7: A `cfgModeReq` of 2'b10 written in full or active mode enters deep sleep.
  - In deep sleep, `coreClkEn`, `sysClkEn`, `pllEn` and `dmaPermit` are all 0.
- R8: In deep sleep, `irq` has no effect.
  - A rising `rtcWakeAsync` takes the mode to full performance on the third clock edge after it rises, because of the two-flop synchronizer.
- R9: The RTC wakeup also wakes sleep, three edges after it rises, with the target chosen by the stored bypass bit.
- R10: Mode requests written in sleep or deep sleep are ignored.
- R11: The lock counter does not advance in deep sleep. After the block wakes, only the remaining count is spent.
- R12: A `cfgModeReq` of 2'b11 is treated as no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgBypass | input | 1 | Bypass bit of the control word |
| cfgMult | input | MULT_W | Requested clock multiplier |
| cfgModeReq | input | 2 | Mode request: 00 none, 01 sleep, 10 deep sleep, 11 none |
| irq | input | 1 | Generic interrupt, synchronous level |
| rtcWakeAsync | input | 1 | RTC wakeup from the always-on domain, asynchronous |
| coreClkEn | output | 1 | Core clock enable |
| sysClkEn | output | 1 | System clock enable |
| pllEn | output | 1 | PLL enable |
| pllBypass | output | 1 | Select input clock instead of PLL output |
| dmaPermit | output | 1 | DMA into local memory permitted |
| multEff | output | MULT_W | Multiplier currently in effect |
| lockDone | output | 1 | Lock counter idle |
| modeState | output | 2 | Current mode encoding |

## Verification
The hardest case to reach is a lock count that is interrupted by deep sleep. It needs a multiplier write, a few running cycles, a deep-sleep request and then an RTC wakeup through the synchronizer. The remaining count after waking then depends on exactly how many edges ran before the request. The bench writes the multiplier, waits a known number of cycles, requests deep sleep and holds there while pulsing `irq`. It then raises the RTC line and counts the cycles `lockDone` stays low, comparing that count with the reload value minus the edges spent in the running modes. Wake targets are swept over both bypass values and both wake sources.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_ACTIVE = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_DEEP   = 2'b11
  } mode_e;

  localparam logic [1:0] REQ_SLEEP = 2'b01;
  localparam logic [1:0] REQ_DEEP  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic pllRun;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic storedBypass;
    logic rtcWake;
  } dpStatus_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int MULT_W = 6,
  parameter logic [MULT_W-1:0] MULT_RST = 10,
  parameter int LOCK_W = 8,
  parameter int LOCK_RELOAD = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgBypass,
  input  logic [MULT_W-1:0] cfgMult,
  input  logic              rtcWakeAsync,
  output dpStatus_t         status,
  output logic [MULT_W-1:0] multEff,
  output logic              lockDone
);

  localparam logic [LOCK_W-1:0] RELOAD_V = LOCK_W'(LOCK_RELOAD);
  localparam logic [LOCK_W-1:0] ONE_V    = LOCK_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   storedBypass;
  logic [MULT_W-1:0]      pendMult;
  logic [LOCK_W-1:0]      lockCnt;
  logic                   multChange;

  // synchronizer for the always-on RTC wakeup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rtcWakeAsync};
  end

  assign status.rtcWake      = syncChain[SYNC_STAGES-1];
  assign status.storedBypass = storedBypass;

  assign multChange = strobe.cfgLoad && (cfgMult != pendMult);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) storedBypass <= 1'b0;
    else if (strobe.cfgLoad) storedBypass <= cfgBypass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMult <= MULT_RST;
      multEff  <= MULT_RST;
      lockCnt  <= '0;
    end else if (multChange) begin
      pendMult <= cfgMult;
      lockCnt  <= RELOAD_V;
    end else if (strobe.pllRun && lockCnt != '0) begin
      lockCnt <= lockCnt - ONE_V;
      if (lockCnt == ONE_V) multEff <= pendMult;
    end
  end

  assign lockDone = (lockCnt == '0);

  // R3
  mult_on_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(multEff) |-> $rose(lockDone));

  // R11
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pllRun && !strobe.cfgLoad) |=> $stable(lockCnt));

  // R8
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status.rtcWake) |-> $past(syncChain[0]));

  initial begin
    if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
    if (LOCK_RELOAD < 1 || LOCK_RELOAD >= (1 << LOCK_W))
      $error("LOCK_RELOAD out of range");
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic      cfgBypass,
  input  logic [1:0] cfgModeReq,
  input  logic      irq,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      coreClkEn,
  output logic      sysClkEn,
  output logic      pllEn,
  output logic      pllBypass,
  output logic      dmaPermit,
  output logic [1:0] modeState
);

  mode_e modeQ, modeD, wakeTarget;

  assign wakeTarget = status.storedBypass ? MODE_ACTIVE : MODE_FULL;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_FULL, MODE_ACTIVE: begin
        if (cfgWrEn) begin
          if (cfgModeReq == REQ_SLEEP)     modeD = MODE_SLEEP;
          else if (cfgModeReq == REQ_DEEP) modeD = MODE_DEEP;
          else modeD = cfgBypass ? MODE_ACTIVE : MODE_FULL;
        end
      end
      MODE_SLEEP: if (irq || status.rtcWake) modeD = wakeTarget;
      MODE_DEEP:  if (status.rtcWake) modeD = MODE_FULL;
      default:    modeD = MODE_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_FULL;
    else       modeQ <= modeD;
  end

  assign strobe.cfgLoad = cfgWrEn;
  assign strobe.pllRun  = (modeQ != MODE_DEEP);

  always_comb begin
    coreClkEn = 1'b0;
    sysClkEn  = 1'b0;
    pllEn     = 1'b0;
    dmaPermit = 1'b0;
    pllBypass = status.storedBypass;
    unique case (modeQ)
      MODE_FULL: begin
        coreClkEn = 1'b1; sysClkEn = 1'b1; pllEn = 1'b1; dmaPermit = 1'b1;
        pllBypass = 1'b0;
      end
      MODE_ACTIVE: begin
        coreClkEn = 1'b1; sysClkEn = 1'b1; pllEn = 1'b1; dmaPermit = 1'b1;
        pllBypass = 1'b1;
      end
      MODE_SLEEP: begin
        sysClkEn = 1'b1; pllEn = 1'b1;
      end
      default: ;
    endcase
  end

  assign modeState = modeQ;

  // R8
  deep_exit_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DEEP) |=> (modeQ == MODE_DEEP || modeQ == MODE_FULL));

  // R8
  deep_irq_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DEEP && !status.rtcWake) |=> (modeQ == MODE_DEEP));

  // R10
  sleep_no_deep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLEEP) |=> (modeQ != MODE_DEEP));

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SLEEP && !irq && !status.rtcWake) |=> (modeQ == MODE_SLEEP));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int MULT_W = 6,
  parameter logic [MULT_W-1:0] MULT_RST = 10,
  parameter int LOCK_W = 8,
  parameter int LOCK_RELOAD = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgBypass,
  input  logic [MULT_W-1:0] cfgMult,
  input  logic [1:0]        cfgModeReq,
  input  logic              irq,
  input  logic              rtcWakeAsync,
  output logic              coreClkEn,
  output logic              sysClkEn,
  output logic              pllEn,
  output logic              pllBypass,
  output logic              dmaPermit,
  output logic [MULT_W-1:0] multEff,
  output logic              lockDone,
  output logic [1:0]        modeState
);

  dpStrobe_t strobe;
  dpStatus_t status;

  pwr_mode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBypass(cfgBypass),
    .cfgModeReq(cfgModeReq), .irq(irq), .status(status), .strobe(strobe),
    .coreClkEn(coreClkEn), .sysClkEn(sysClkEn), .pllEn(pllEn),
    .pllBypass(pllBypass), .dmaPermit(dmaPermit), .modeState(modeState)
  );

  pwr_mode_dp #(
    .MULT_W(MULT_W), .MULT_RST(MULT_RST), .LOCK_W(LOCK_W),
    .LOCK_RELOAD(LOCK_RELOAD), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBypass(cfgBypass),
    .cfgMult(cfgMult), .rtcWakeAsync(rtcWakeAsync), .status(status),
    .multEff(multEff), .lockDone(lockDone)
  );

  // R7
  core_needs_sys_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |-> sysClkEn);

  // R5
  dma_follows_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaPermit == coreClkEn);

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int MW = 6;
  localparam logic [MW-1:0] MRST = 10;
  localparam int RELOAD = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgBypass = 1'b0, irq = 1'b0, rtcWakeAsync = 1'b0;
  logic [MW-1:0] cfgMult = MRST;
  logic [1:0] cfgModeReq = 2'b00;
  logic coreClkEn, sysClkEn, pllEn, pllBypass, dmaPermit, lockDone;
  logic [MW-1:0] multEff;
  logic [1:0] modeState;

  int checks = 0;
  int failures = 0;
  logic bypExp = 1'b0;
  logic [MW-1:0] curMult = MRST;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.MULT_W(MW), .MULT_RST(MRST), .LOCK_W(8), .LOCK_RELOAD(RELOAD)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBypass(cfgBypass),
    .cfgMult(cfgMult), .cfgModeReq(cfgModeReq), .irq(irq),
    .rtcWakeAsync(rtcWakeAsync), .coreClkEn(coreClkEn), .sysClkEn(sysClkEn),
    .pllEn(pllEn), .pllBypass(pllBypass), .dmaPermit(dmaPermit),
    .multEff(multEff), .lockDone(lockDone), .modeState(modeState)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outputs expected from a mode code: {core,sys,pllEn,byp,dma}
  task automatic chkMode(input logic [1:0] m, input string tag);
    logic [4:0] exp, act;
    exp = {m < 2'd2, m != 2'd3, m != 2'd3,
           (m == 2'd1) || (m >= 2'd2 && bypExp), m < 2'd2};
    act = {coreClkEn, sysClkEn, pllEn, pllBypass, dmaPermit};
    chk(modeState == m, {tag, " mode"}, modeState, m);
    chk(act == exp, {tag, " enables"}, act, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic b, input logic [MW-1:0] m, input logic [1:0] req);
    cfgWrEn = 1'b1; cfgBypass = b; cfgMult = m; cfgModeReq = req;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgModeReq = 2'b00;
    bypExp = b;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chkMode(2'd0, "R1");
    chk(lockDone == 1'b1, "R1 lockDone", lockDone, 1);
    chk(multEff == MRST, "R1 multEff", multEff, MRST);

    // R2 / R12 bypass toggling via no-request writes
    wr(1'b1, curMult, 2'b00); chkMode(2'd1, "R2 to active");
    wr(1'b0, curMult, 2'b11); chkMode(2'd0, "R12 code 11 no request");
    wr(1'b1, curMult, 2'b11); chkMode(2'd1, "R12 code 11 bypass");
    wr(1'b0, curMult, 2'b00); chkMode(2'd0, "R2 to full");

    // R5 R6 R9 sweep: bypass x wake source
    for (int b = 0; b < 2; b++) begin
      for (int src = 0; src < 2; src++) begin
        wr(b[0], curMult, 2'b00);
        wr(b[0], curMult, 2'b01);
        chkMode(2'd2, "R5 sleep entry");
        wr(b[0], curMult, 2'b10);
        chkMode(2'd2, "R10 request ignored in sleep");
        if (src == 0) begin
          irq = 1'b1; step(1); irq = 1'b0;
          chkMode(b[0] ? 2'd1 : 2'd0, "R6 irq wake");
        end else begin
          rtcWakeAsync = 1'b1; step(2);
          chkMode(2'd2, "R9 still asleep during sync");
          step(1); rtcWakeAsync = 1'b0;
          chkMode(b[0] ? 2'd1 : 2'd0, "R9 rtc wake");
          step(3);
        end
      end
    end

    // R7 R8 deep sleep entry, irq ignored, rtc exit to full
    wr(1'b1, curMult, 2'b00);
    wr(1'b1, curMult, 2'b10);
    chkMode(2'd3, "R7 deep entry");
    irq = 1'b1; step(4); irq = 1'b0;
    chkMode(2'd3, "R8 irq ignored in deep");
    wr(1'b1, curMult, 2'b01);
    chkMode(2'd3, "R10 request ignored in deep");
    rtcWakeAsync = 1'b1; step(1);
    chkMode(2'd3, "R8 deep after edge 1");
    step(1);
    chkMode(2'd3, "R8 deep after edge 2");
    step(1); rtcWakeAsync = 1'b0;
    chkMode(2'd0, "R8 rtc exit to full");
    step(3);
    wr(1'b0, curMult, 2'b00);

    // R3 sweep multipliers with lock timing
    for (int k = 0; k < 6; k++) begin
      logic [MW-1:0] nm;
      int n;
      logic held;
      nm = MW'(3 + 7 * k);
      wr(1'b0, nm, 2'b00);
      chk(lockDone == 1'b0, "R3 lockDone drops", lockDone, 0);
      n = 0; held = 1'b1;
      while (!lockDone && n < 100) begin
        if (multEff != curMult) held = 1'b0;
        step(1); n++;
      end
      chk(held, "R3 multEff held while locking", 0, 1);
      chk(n == RELOAD, "R3 lock cycles", n, RELOAD);
      chk(multEff == nm, "R3 multEff updated", multEff, nm);
      curMult = nm;
    end

    // R4 same value does not restart; different value restarts
    begin
      int n;
      wr(1'b0, 6'd50, 2'b00);
      step(4);
      wr(1'b0, 6'd50, 2'b00);
      n = 5;
      while (!lockDone && n < 100) begin step(1); n++; end
      chk(n == RELOAD, "R4 same value no restart", n, RELOAD);
      curMult = 6'd50;
      wr(1'b0, 6'd20, 2'b00);
      step(5);
      wr(1'b0, 6'd21, 2'b00);
      chk(multEff == 6'd50, "R4 old value kept", multEff, 50);
      n = 0;
      while (!lockDone && n < 100) begin step(1); n++; end
      chk(n == RELOAD, "R4 restart full count", n, RELOAD);
      chk(multEff == 6'd21, "R4 final value", multEff, 21);
      curMult = 6'd21;
    end

    // R11 lock count frozen in deep sleep
    begin
      int n;
      wr(1'b0, 6'd33, 2'b00);
      step(3);
      wr(1'b0, 6'd33, 2'b10);   // 4 running edges consumed
      chkMode(2'd3, "R11 deep");
      step(10);
      chk(lockDone == 1'b0, "R11 frozen lockDone", lockDone, 0);
      chk(multEff == curMult, "R11 frozen multEff", multEff, curMult);
      rtcWakeAsync = 1'b1; step(3); rtcWakeAsync = 1'b0;
      chkMode(2'd0, "R11 woke");
      n = 0;
      while (!lockDone && n < 100) begin step(1); n++; end
      chk(n == RELOAD - 4, "R11 remaining count", n, RELOAD - 4);
      chk(multEff == 6'd33, "R11 multEff", multEff, 33);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule